// File: doc/BRIEF.md
# Ramp Gain-Ratio Calibration Sequencer

This block calibrates the slope mismatch between the main ramp of a column single-slope converter and its auxiliary, higher-gain ramps. On a start request it runs a fixed series of conversions for each auxiliary ramp. It drives a preset-level select and a forced-ramp select, raises a conversion request, and takes the returned code when the converter reports completion. A low preset is converted on both ramps. Two high presets are converted one on each ramp. From the two spans the block derives a fixed-point ratio with a sequential divider.

Each ratio is held in a per-ramp coefficient register with a valid flag. A one-stage correction path runs alongside. Every code tagged as taken on an auxiliary ramp is rescaled by that ramp's ratio, which moves it onto the main-ramp scale at the junctions between ramps. Codes from the main ramp pass through unchanged. The correction path keeps running while a calibration is in progress.

Top module: `rgr_cal_seq`

## Requirements
- R1: After reset, cal_busy, conv_req and out_vld are 0, every coefficient holds 1.0 (4096 in Q4.12) and every beta_ok bit is 0.
- R2: cal_start seen while idle makes cal_busy 1 from the next cycle until the whole sequence ends; a cal_start seen while busy is ignored and starts no further conversions.
- R3: For each auxiliary ramp j = 1..N_AUX, in ascending order, exactly four conversions are requested as (preset_sel, force_ramp) pairs: (0,0), (0,j), (1,j), (2,0). Here preset_sel 0 is the shared low preset, 1 is the high preset for the auxiliary ramp and 2 is the high preset for the main ramp; force_ramp 0 is the main ramp and j is auxiliary ramp j. A full calibration requests 4*N_AUX conversions.
- R4: conv_req stays high, with preset_sel and force_ramp stable, until conv_done is sampled high. conv_code is taken in that cycle, and conv_req is low in the following cycle.
- R5: Let num = main-high code minus main-low code and den = aux-high code minus aux-low code. When den > 0 and num >= 0, coefficient j becomes floor(num*4096/den) and beta_ok[j] becomes 1.
- R6: A quotient above 65535 is saturated to 65535, and beta_ok[j] is still 1.
- R7: When den <= 0 or num < 0, coefficient j becomes 4096 and beta_ok[j] becomes 0.
- R8: An input with in_ramp = 0 appears unchanged (zero-extended) on out_code one cycle later.
- R9: An input with in_ramp = j (1..N_AUX) appears one cycle later as floor(in_code*beta_j/4096), using the coefficient held in the input cycle. out_vld follows in_vld with one cycle of latency.
- R10: Each coefficient keeps its previous value during a calibration until its own ramp's result is written, and the correction path keeps serving inputs throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Calibration start request |
| cal_busy | output | 1 | High while the calibration runs |
| conv_req | output | 1 | Conversion request to the column converter |
| preset_sel | output | 2 | Preset level to apply (0 low, 1 aux-high, 2 main-high) |
| force_ramp | output | RS_W | Ramp to force (0 main, j auxiliary j) |
| conv_done | input | 1 | Conversion finished, code valid |
| conv_code | input | CODE_W | Converted code |
| beta_flat | output | N_AUX*BETA_W | Coefficients, ramp j at bits j-1 |
| beta_ok | output | N_AUX | Coefficient valid flags |
| in_vld | input | 1 | Correction input valid |
| in_ramp | input | RS_W | Ramp the input code was taken on |
| in_code | input | CODE_W | Code to correct |
| out_vld | output | 1 | Corrected code valid |
| out_code | output | CODE_W+BETA_W-FRAC | Corrected code |

## Verification
A coefficient write at the end of a division can land in the same cycle as a correction input on that ramp. The correction must use the coefficient that held before the write. The bench drives a correction input on every cycle of a calibration, cycling over all ramps, while a previous calibration has left non-default coefficients in place. Each corrected code is judged against the coefficient seen on the port in the cycle the input was applied, and the final coefficients are compared with values computed arithmetically from the converter model's codes.

// File: rtl/rgr_cal_pkg.sv
package rgr_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_CONV, ST_PREP, ST_DIV, ST_NEXT
  } cal_state_e;

  localparam logic [1:0] PS_LOW   = 2'd0;
  localparam logic [1:0] PS_AUXH  = 2'd1;
  localparam logic [1:0] PS_MAINH = 2'd2;
endpackage

// File: rtl/rgr_divider.sv
module rgr_divider #(
  parameter int NUM_W = 12,
  parameter int DEN_W = 12,
  parameter int FRAC  = 12,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   quo
);
  localparam int DIVD_W = NUM_W + FRAC;
  localparam int CNT_W  = $clog2(DIVD_W);

  logic              run_q, run_d, done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DIVD_W-1:0] sh_q, sh_d;
  logic [DEN_W-1:0]  rem_q, rem_d, den_q, den_d;
  logic [DEN_W:0]    rem_sh, rem_sub;
  logic              ge;

  assign rem_sh  = {rem_q, sh_q[DIVD_W-1]};
  assign rem_sub = rem_sh - {1'b0, den_q};
  assign ge      = (rem_sh >= {1'b0, den_q});

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    rem_d  = rem_q;
    den_d  = den_q;
    done_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
      sh_d  = {num, {FRAC{1'b0}}};
      rem_d = '0;
      den_d = den;
    end else if (run_q) begin
      sh_d  = {sh_q[DIVD_W-2:0], ge};
      rem_d = ge ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
      if (cnt_q == CNT_W'(DIVD_W-1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rem_q  <= '0;
      den_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
    end
  end

  assign done = done_q;
  assign quo  = (|sh_q[DIVD_W-1:Q_W]) ? {Q_W{1'b1}} : sh_q[Q_W-1:0];
endmodule

// File: rtl/rgr_corrector.sv
module rgr_corrector #(
  parameter int CODE_W = 12,
  parameter int BETA_W = 16,
  parameter int FRAC   = 12,
  parameter int N_AUX  = 3,
  parameter int RS_W   = 2,
  parameter int OUT_W  = CODE_W + BETA_W - FRAC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [RS_W-1:0]         in_ramp,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [N_AUX*BETA_W-1:0] beta_flat,
  output logic                    out_vld,
  output logic [OUT_W-1:0]        out_code
);
  localparam int PROD_W = CODE_W + BETA_W;

  logic [BETA_W-1:0] sel_beta;
  logic              use_aux;
  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  corr, code_q;
  logic              vld_q;

  always_comb begin
    sel_beta = '0;
    use_aux  = 1'b0;
    for (int j = 0; j < N_AUX; j++) begin
      if (in_ramp == RS_W'(j + 1)) begin
        sel_beta = beta_flat[j*BETA_W +: BETA_W];
        use_aux  = 1'b1;
      end
    end
    prod = PROD_W'(in_code) * PROD_W'(sel_beta);
    corr = use_aux ? prod[PROD_W-1:FRAC] : OUT_W'(in_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) code_q <= corr;
    end
  end

  assign out_vld  = vld_q;
  assign out_code = code_q;
endmodule

// File: rtl/rgr_cal_seq.sv
module rgr_cal_seq
  import rgr_cal_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BETA_W = 16,
  parameter int FRAC   = 12,
  parameter int N_AUX  = 3,
  localparam int RS_W  = $clog2(N_AUX + 1),
  localparam int OUT_W = CODE_W + BETA_W - FRAC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cal_start,
  output logic                    cal_busy,
  output logic                    conv_req,
  output logic [1:0]              preset_sel,
  output logic [RS_W-1:0]         force_ramp,
  input  logic                    conv_done,
  input  logic [CODE_W-1:0]       conv_code,
  output logic [N_AUX*BETA_W-1:0] beta_flat,
  output logic [N_AUX-1:0]        beta_ok,
  input  logic                    in_vld,
  input  logic [RS_W-1:0]         in_ramp,
  input  logic [CODE_W-1:0]       in_code,
  output logic                    out_vld,
  output logic [OUT_W-1:0]        out_code
);
  localparam logic [BETA_W-1:0] BETA_ONE = BETA_W'(1) << FRAC;

  cal_state_e        st_q, st_d;
  logic [1:0]        step_q, step_d;
  logic [RS_W-1:0]   kidx_q, kidx_d;
  logic [CODE_W-1:0] cap_q [4];
  logic              cap_we;
  logic [BETA_W-1:0] beta_q [N_AUX];
  logic [N_AUX-1:0]  ok_q;
  logic              beta_we, ok_wval;
  logic [BETA_W-1:0] beta_wval;
  logic [CODE_W:0]   num_diff, den_diff;
  logic              ratio_bad, div_start, div_done;
  logic [BETA_W-1:0] div_quo;

  // capture slots: 0 main-low, 1 aux-low, 2 aux-high, 3 main-high
  assign num_diff  = {1'b0, cap_q[3]} - {1'b0, cap_q[0]};
  assign den_diff  = {1'b0, cap_q[2]} - {1'b0, cap_q[1]};
  assign ratio_bad = num_diff[CODE_W] | den_diff[CODE_W] | (den_diff == '0);

  rgr_divider #(
    .NUM_W(CODE_W), .DEN_W(CODE_W), .FRAC(FRAC), .Q_W(BETA_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (num_diff[CODE_W-1:0]),
    .den   (den_diff[CODE_W-1:0]),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_comb begin
    st_d      = st_q;
    step_d    = step_q;
    kidx_d    = kidx_q;
    cap_we    = 1'b0;
    div_start = 1'b0;
    beta_we   = 1'b0;
    beta_wval = BETA_ONE;
    ok_wval   = 1'b0;
    case (st_q)
      ST_IDLE: if (cal_start) begin
        st_d   = ST_ARM;
        step_d = '0;
        kidx_d = '0;
      end
      ST_ARM:  st_d = ST_CONV;
      ST_CONV: if (conv_done) begin
        cap_we = 1'b1;
        if (step_q == 2'd3) st_d = ST_PREP;
        else begin
          step_d = step_q + 1'b1;
          st_d   = ST_ARM;
        end
      end
      ST_PREP: if (ratio_bad) begin
        beta_we = 1'b1;
        st_d    = ST_NEXT;
      end else begin
        div_start = 1'b1;
        st_d      = ST_DIV;
      end
      ST_DIV: if (div_done) begin
        beta_we   = 1'b1;
        beta_wval = div_quo;
        ok_wval   = 1'b1;
        st_d      = ST_NEXT;
      end
      ST_NEXT: if (kidx_q == RS_W'(N_AUX - 1)) st_d = ST_IDLE;
      else begin
        kidx_d = kidx_q + 1'b1;
        step_d = '0;
        st_d   = ST_ARM;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      kidx_q <= '0;
      ok_q   <= '0;
      for (int i = 0; i < 4; i++) cap_q[i] <= '0;
      for (int j = 0; j < N_AUX; j++) beta_q[j] <= BETA_ONE;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      kidx_q <= kidx_d;
      if (cap_we) cap_q[step_q] <= conv_code;
      if (beta_we) begin
        beta_q[kidx_q] <= beta_wval;
        ok_q[kidx_q]   <= ok_wval;
      end
    end
  end

  assign cal_busy   = (st_q != ST_IDLE);
  assign conv_req   = (st_q == ST_CONV);
  assign preset_sel = (step_q == 2'd2) ? PS_AUXH :
                      (step_q == 2'd3) ? PS_MAINH : PS_LOW;
  assign force_ramp = (step_q == 2'd1 || step_q == 2'd2) ? RS_W'(kidx_q + 1'b1) : '0;
  assign beta_ok    = ok_q;

  for (genvar g = 0; g < N_AUX; g++) begin : g_beta
    assign beta_flat[g*BETA_W +: BETA_W] = beta_q[g];
  end

  rgr_corrector #(
    .CODE_W(CODE_W), .BETA_W(BETA_W), .FRAC(FRAC), .N_AUX(N_AUX), .RS_W(RS_W), .OUT_W(OUT_W)
  ) u_corr (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_ramp   (in_ramp),
    .in_code   (in_code),
    .beta_flat (beta_flat),
    .out_vld   (out_vld),
    .out_code  (out_code)
  );
endmodule

// File: rtl/rgr_cal_seq_chk.sv
module rgr_cal_seq_chk #(
  parameter int CODE_W = 12,
  parameter int BETA_W = 16,
  parameter int FRAC   = 12,
  parameter int N_AUX  = 3,
  parameter int RS_W   = 2,
  parameter int OUT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cal_start,
  input logic                    cal_busy,
  input logic                    conv_req,
  input logic [1:0]              preset_sel,
  input logic [RS_W-1:0]         force_ramp,
  input logic                    conv_done,
  input logic [N_AUX*BETA_W-1:0] beta_flat,
  input logic [N_AUX-1:0]        beta_ok,
  input logic                    in_vld,
  input logic [RS_W-1:0]         in_ramp,
  input logic [CODE_W-1:0]       in_code,
  input logic                    out_vld,
  input logic [OUT_W-1:0]        out_code
);
  localparam logic [BETA_W-1:0] ONE = BETA_W'(1) << FRAC;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start && !cal_busy |=> cal_busy);

  p_req_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> cal_busy);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req && $stable(preset_sel) && $stable(force_ramp));

  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_done |=> !conv_req);

  p_legal_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (preset_sel == 2'd0) ||
                 (preset_sel == 2'd1 && force_ramp != '0) ||
                 (preset_sel == 2'd2 && force_ramp == '0));

  p_vld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  p_vld_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  p_main_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && in_ramp == '0 |=> out_code == OUT_W'($past(in_code)));

  for (genvar g = 0; g < N_AUX; g++) begin : g_def
    p_bad_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !beta_ok[g] |-> beta_flat[g*BETA_W +: BETA_W] == ONE);
  end
endmodule

bind rgr_cal_seq rgr_cal_seq_chk #(
  .CODE_W(CODE_W), .BETA_W(BETA_W), .FRAC(FRAC), .N_AUX(N_AUX), .RS_W(RS_W), .OUT_W(OUT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cal_start  (cal_start),
  .cal_busy   (cal_busy),
  .conv_req   (conv_req),
  .preset_sel (preset_sel),
  .force_ramp (force_ramp),
  .conv_done  (conv_done),
  .beta_flat  (beta_flat),
  .beta_ok    (beta_ok),
  .in_vld     (in_vld),
  .in_ramp    (in_ramp),
  .in_code    (in_code),
  .out_vld    (out_vld),
  .out_code   (out_code)
);

// File: tb/test_rgr_cal_seq.sv
`timescale 1ns/1ps
module test_rgr_cal_seq;
  localparam int CODE_W = 12;
  localparam int BETA_W = 16;
  localparam int FRAC   = 12;
  localparam int N_AUX  = 3;
  localparam int RS_W   = 2;
  localparam int OUT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 1'b0;
  logic cal_busy, conv_req, conv_done, in_vld, out_vld;
  logic [1:0] preset_sel;
  logic [RS_W-1:0] force_ramp, in_ramp;
  logic [CODE_W-1:0] conv_code, in_code;
  logic [N_AUX*BETA_W-1:0] beta_flat;
  logic [N_AUX-1:0] beta_ok;
  logic [OUT_W-1:0] out_code;

  int total = 0;
  int bad = 0;
  int seqi = 0;
  int nreq = 0;
  int lo1, hi1;
  int lok [3];
  int hik [3];
  int pb [3];

  always #2.5 clk = ~clk;

  rgr_cal_seq i_rgr_cal_seq (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_busy(cal_busy),
    .conv_req(conv_req), .preset_sel(preset_sel), .force_ramp(force_ramp),
    .conv_done(conv_done), .conv_code(conv_code), .beta_flat(beta_flat),
    .beta_ok(beta_ok), .in_vld(in_vld), .in_ramp(in_ramp), .in_code(in_code),
    .out_vld(out_vld), .out_code(out_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int beta_of(input int j);
    return int'(beta_flat[j*BETA_W +: BETA_W]);
  endfunction

  function automatic int exp_beta(input int n, input int d);
    longint q;
    if (d <= 0 || n < 0) return 4096;
    q = (longint'(n) * 4096) / d;
    if (q > 65535) return 65535;
    return int'(q);
  endfunction

  // converter model: answers by the pair actually requested
  initial begin
    conv_done = 1'b0;
    conv_code = '0;
    forever begin
      @(negedge clk);
      if (rst_n && conv_req === 1'b1) begin
        int ej, es, esel, eramp, code;
        logic [1:0] ps;
        logic [RS_W-1:0] fr;
        ej = seqi / 4 + 1;
        es = seqi % 4;
        esel  = (es == 2) ? 1 : (es == 3) ? 2 : 0;
        eramp = (es == 1 || es == 2) ? ej : 0;
        ps = preset_sel;
        fr = force_ramp;
        chk(int'(ps) == esel, "R3 preset order", int'(ps), esel);
        chk(int'(fr) == eramp, "R3 ramp order", int'(fr), eramp);
        if (ps == 2'd0 && fr == '0) code = lo1;
        else if (ps == 2'd2) code = hi1;
        else if (ps == 2'd0) code = lok[int'(fr) - 1];
        else code = hik[int'(fr) - 1];
        repeat (2) @(negedge clk);
        chk(conv_req === 1'b1 && preset_sel == ps && force_ramp == fr,
            "R4 request held", int'(conv_req), 1);
        conv_done = 1'b1;
        conv_code = CODE_W'(code);
        @(negedge clk);
        chk(conv_req === 1'b0, "R4 request dropped", int'(conv_req), 0);
        conv_done = 1'b0;
        seqi++;
        nreq++;
      end
    end
  end

  task automatic set_scen(input int s);
    case (s)
      0: begin lo1 = 100; hi1 = 1100;
         lok = '{200, 50, 0};   hik = '{2200, 1050, 4000}; end
      1: begin lo1 = 10;  hi1 = 4010;
         lok = '{0, 300, 500};  hik = '{100, 300, 400}; end
      2: begin lo1 = 3000; hi1 = 1000;
         lok = '{10, 20, 30};   hik = '{900, 800, 700}; end
      default: begin lo1 = 7; hi1 = 3001;
         lok = '{11, 1, 0};     hik = '{4000, 2999, 4095}; end
    endcase
  endtask

  task automatic run_cal(input int s, input bit conc);
    int cyc, eb, en, ed, expc, ramp, code;
    bit pend;
    set_scen(s);
    seqi = 0;
    nreq = 0;
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    chk(cal_busy === 1'b1, "R2 busy after start", int'(cal_busy), 1);
    for (int j = 0; j < N_AUX; j++)
      chk(beta_of(j) == pb[j], "R10 coefficient kept at start", beta_of(j), pb[j]);
    cyc = 0;
    pend = 1'b0;
    expc = 0;
    while (1) begin
      if (pend) begin
        chk(out_vld === 1'b1 && int'(out_code) == expc,
            "R10 correction during calibration", int'(out_code), expc);
        pend = 1'b0;
      end
      if (!cal_busy || cyc > 3000) break;
      if (conc) begin
        ramp = cyc % 4;
        code = (cyc * 37 + 5) % 4096;
        in_vld = 1'b1;
        in_ramp = RS_W'(ramp);
        in_code = CODE_W'(code);
        expc = (ramp == 0) ? code : (code * beta_of(ramp - 1)) >>> 12;
        pend = 1'b1;
      end else begin
        in_vld = 1'b0;
      end
      cal_start = (cyc == 20);
      @(negedge clk);
      cyc++;
    end
    in_vld = 1'b0;
    cal_start = 1'b0;
    chk(cyc <= 3000, "R2 calibration ends", cyc, 3000);
    chk(nreq == 4 * N_AUX, "R3 request count", nreq, 4 * N_AUX);
    en = hi1 - lo1;
    for (int j = 0; j < N_AUX; j++) begin
      ed = hik[j] - lok[j];
      eb = exp_beta(en, ed);
      if (ed <= 0 || en < 0) begin
        chk(beta_of(j) == 4096, "R7 invalid default", beta_of(j), 4096);
        chk(beta_ok[j] === 1'b0, "R7 invalid flag", int'(beta_ok[j]), 0);
      end else if (eb == 65535) begin
        chk(beta_of(j) == eb, "R6 saturation", beta_of(j), eb);
        chk(beta_ok[j] === 1'b1, "R6 flag", int'(beta_ok[j]), 1);
      end else begin
        chk(beta_of(j) == eb, "R5 ratio", beta_of(j), eb);
        chk(beta_ok[j] === 1'b1, "R5 flag", int'(beta_ok[j]), 1);
      end
      pb[j] = eb;
    end
    repeat (10) @(negedge clk);
    chk(cal_busy === 1'b0, "R2 start while busy ignored", int'(cal_busy), 0);
    chk(nreq == 4 * N_AUX, "R2 no extra requests", nreq, 4 * N_AUX);
  endtask

  task automatic sweep_corr();
    int expc;
    for (int r = 0; r <= N_AUX; r++) begin
      for (int c = 0; c < 4096 + 97; c += 97) begin
        int cc;
        cc = (c > 4095) ? 4095 : c;
        @(negedge clk);
        in_vld = 1'b1;
        in_ramp = RS_W'(r);
        in_code = CODE_W'(cc);
        expc = (r == 0) ? cc : (cc * pb[r - 1]) >>> 12;
        @(negedge clk);
        in_vld = 1'b0;
        if (r == 0)
          chk(out_vld === 1'b1 && int'(out_code) == expc, "R8 main passthrough", int'(out_code), expc);
        else
          chk(out_vld === 1'b1 && int'(out_code) == expc, "R9 aux scaling", int'(out_code), expc);
      end
    end
    @(negedge clk);
    chk(out_vld === 1'b0, "R9 valid latency", int'(out_vld), 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_vld = 1'b0;
    in_ramp = '0;
    in_code = '0;
    for (int j = 0; j < 3; j++) pb[j] = 4096;
    lo1 = 0; hi1 = 0;
    lok = '{0, 0, 0};
    hik = '{0, 0, 0};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cal_busy === 1'b0, "R1 busy at reset", int'(cal_busy), 0);
    chk(conv_req === 1'b0, "R1 request at reset", int'(conv_req), 0);
    chk(out_vld === 1'b0, "R1 out valid at reset", int'(out_vld), 0);
    chk(beta_ok === '0, "R1 flags at reset", int'(beta_ok), 0);
    for (int j = 0; j < N_AUX; j++)
      chk(beta_of(j) == 4096, "R1 coefficient at reset", beta_of(j), 4096);
    sweep_corr();
    run_cal(0, 1'b0);
    sweep_corr();
    run_cal(1, 1'b1);
    sweep_corr();
    run_cal(2, 1'b0);
    run_cal(3, 1'b1);
    sweep_corr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule